// File: doc/BRIEF.md
# Link power monitor and wake controller

This block sits in the system clock domain (about 49.152 MHz) next to the PHY-to-link interface. It follows the link-power-status input and measures how long each period without link power lasts. A short dropout ends with a one-cycle request to reset the PHY-to-link interface. A long dropout turns the interface off. The interface comes back on as soon as power status returns.

While the link has no power, the block can wake it. It drives a slow square wave on a wake output while a wake cause is held. The causes are a link-on packet addressed to this node, or an interrupt condition flagged by the register file. Each cause has its own clearing rule. Bus-reset handling, which clears some causes and not others, is part of this block.

Thresholds are given in clock cycles. The wake divider ratio and the synchronizer depth are parameters.

Top module: `lps_wake_ctrl`

## Requirements
- R1: After reset, `if_enable_o` is 1 and both `if_reset_o` and `wake_o` are 0.
- R2: `link_pwr_i` (1 = link powered) passes through SYNC_STAGES flip-flops, reset to 1, before any use. A dropout's length L is the number of consecutive cycles the synchronized value is 0.
- R3: When the synchronized status returns to 1 after a dropout with SHORT_CYC < L <= LONG_CYC, `if_reset_o` is high for exactly one cycle, one cycle after the synchronized value returns. A dropout with L <= SHORT_CYC gives no pulse.
- R4: A dropout with L > LONG_CYC drives `if_enable_o` low one cycle after the count reaches LONG_CYC. No `if_reset_o` pulse follows that dropout.
- R5: One cycle after the synchronized status is 1, `if_enable_o` is 1 and `wake_o` is 0. Every latched wake cause is cleared.
- R6: A `linkon_pkt_i` strobe seen while the synchronized status is 0 latches a packet wake cause. A strobe seen while the status is 1 has no effect.
- R7: The interrupt condition is `port_event_i | (resume_int_i & (timeout_i | pwr_fail_i | loop_i))`. It latches a wake cause in any cycle where the synchronized status is 0. A condition already held while the status is 1 therefore arms the wake output at the next inactive period. `resume_int_i` alone, or the error flags without it, do not wake.
- R8: A `bus_reset_i` strobe clears the packet cause. It takes priority over a packet strobe in the same cycle. It leaves a latched interrupt cause, and so the wake output, running.
- R9: While any cause is latched, `wake_o` is a 50% square wave of period WAKE_DIV cycles from a free-running divider. After the e-th clock edge since reset, the divider phase is floor(e / (WAKE_DIV/2)) mod 2. `wake_o` is low while no cause is latched.
- R10: The dropout counter saturates at LONG_CYC, so a dropout of any length keeps the interface disabled and never wraps back into the reset window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_pwr_i | input | 1 | Link power status, 1 = powered (asynchronous) |
| linkon_pkt_i | input | 1 | One-cycle strobe: link-on packet for this node received |
| bus_reset_i | input | 1 | One-cycle strobe: bus reset occurred |
| port_event_i | input | 1 | Port event interrupt flag |
| timeout_i | input | 1 | Timeout interrupt flag |
| pwr_fail_i | input | 1 | Cable power fail interrupt flag |
| loop_i | input | 1 | Loop detected interrupt flag |
| resume_int_i | input | 1 | Enables the error flags as wake causes |
| if_reset_o | output | 1 | One-cycle PHY-to-link interface reset request |
| if_enable_o | output | 1 | PHY-to-link interface enable level |
| wake_o | output | 1 | Link-on wake square wave, low when idle |

## Verification
The properties assume `linkon_pkt_i` and `bus_reset_i` are single-cycle strobes. They also assume the interrupt flags are levels that are stable around the clock edge. The bench drives every input on the falling edge and holds flags for many cycles. It pulses the strobes for one cycle only. Power-status dropouts are held for whole numbers of cycles, so the synchronized length equals the driven length, including dropouts placed exactly on both thresholds.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

   typedef struct packed {
      logic port_event;
      logic timeout;
      logic pwr_fail;
      logic loop_det;
      logic resume_en;
   } lpw_irq_t;

   function automatic logic irq_wants_wake(input lpw_irq_t f);
      return f.port_event | (f.resume_en & (f.timeout | f.pwr_fail | f.loop_det));
   endfunction

   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("lpw_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] pipe_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
         else        pipe_q <= d_i;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
         else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/lpw_dropout.sv
module lpw_dropout #(
   parameter int SHORT_CYC = 59,
   parameter int LONG_CYC  = 1229,
   parameter int CW        = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          live_i,
   output logic [CW-1:0] cnt_o,
   output logic          if_reset_o,
   output logic          if_enable_o
);

   localparam logic [CW-1:0] SHORT_C = CW'(SHORT_CYC);
   localparam logic [CW-1:0] LONG_C  = CW'(LONG_CYC);

   logic [CW-1:0] cnt_q;
   logic          en_q;
   logic          pulse_q;
   logic          at_ceiling;

   assign at_ceiling = (cnt_q == LONG_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (live_i)      cnt_q <= '0;
      else if (!at_ceiling) cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          en_q <= 1'b1;
      else if (live_i)     en_q <= 1'b1;
      else if (at_ceiling) en_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= live_i & en_q & (cnt_q > SHORT_C);
   end

   assign cnt_o       = cnt_q;
   assign if_reset_o  = pulse_q;
   assign if_enable_o = en_q;

endmodule

// File: rtl/lpw_wake.sv
module lpw_wake
   import lpw_pkg::*;
#(
   parameter int WAKE_DIV = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     live_i,
   input  logic     pkt_i,
   input  logic     bus_rst_i,
   input  lpw_irq_t irq_i,
   output logic     pkt_lat_o,
   output logic     irq_lat_o,
   output logic     wake_o
);

   localparam int HALF = WAKE_DIV / 2;
   localparam int HCW  = cnt_width(HALF - 1);

   logic pkt_q, irq_q, phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pkt_q <= 1'b0;
      else if (live_i)    pkt_q <= 1'b0;
      else if (bus_rst_i) pkt_q <= 1'b0;
      else if (pkt_i)     pkt_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     irq_q <= 1'b0;
      else if (live_i)                irq_q <= 1'b0;
      else if (irq_wants_wake(irq_i)) irq_q <= 1'b1;
   end

   if (HALF == 1) begin : g_div2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) phase_q <= 1'b0;
         else        phase_q <= ~phase_q;
      end
   end else begin : g_divn
      localparam logic [HCW-1:0] TOP = HCW'(HALF - 1);
      logic [HCW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q   <= '0;
            phase_q <= 1'b0;
         end else if (div_q == TOP) begin
            div_q   <= '0;
            phase_q <= ~phase_q;
         end else begin
            div_q   <= div_q + 1'b1;
         end
      end
   end

   assign pkt_lat_o = pkt_q;
   assign irq_lat_o = irq_q;
   assign wake_o    = (pkt_q | irq_q) & phase_q;

endmodule

// File: rtl/lps_wake_ctrl.sv
module lps_wake_ctrl
   import lpw_pkg::*;
#(
   parameter int SHORT_CYC   = 59,
   parameter int LONG_CYC    = 1229,
   parameter int WAKE_DIV    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_pwr_i,
   input  logic linkon_pkt_i,
   input  logic bus_reset_i,
   input  logic port_event_i,
   input  logic timeout_i,
   input  logic pwr_fail_i,
   input  logic loop_i,
   input  logic resume_int_i,
   output logic if_reset_o,
   output logic if_enable_o,
   output logic wake_o
);

   localparam int CNT_W = cnt_width(LONG_CYC);

   if (SHORT_CYC < 1 || LONG_CYC <= SHORT_CYC) begin : g_bad_thresh
      $error("lps_wake_ctrl: need 1 <= SHORT_CYC < LONG_CYC");
   end
   if (WAKE_DIV < 2 || (WAKE_DIV % 2) != 0) begin : g_bad_div
      $error("lps_wake_ctrl: WAKE_DIV must be even and >= 2");
   end

   logic             live_s;
   logic [CNT_W-1:0] drop_cnt;
   logic             pkt_lat, irq_lat;
   lpw_irq_t         irq_flags;

   assign irq_flags = '{port_event: port_event_i, timeout: timeout_i,
                        pwr_fail: pwr_fail_i, loop_det: loop_i,
                        resume_en: resume_int_i};

   lpw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (link_pwr_i),
      .q_o   (live_s)
   );

   lpw_dropout #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .CW(CNT_W)) u_drop (
      .clk         (clk),
      .rst_n       (rst_n),
      .live_i      (live_s),
      .cnt_o       (drop_cnt),
      .if_reset_o  (if_reset_o),
      .if_enable_o (if_enable_o)
   );

   lpw_wake #(.WAKE_DIV(WAKE_DIV)) u_wake (
      .clk       (clk),
      .rst_n     (rst_n),
      .live_i    (live_s),
      .pkt_i     (linkon_pkt_i),
      .bus_rst_i (bus_reset_i),
      .irq_i     (irq_flags),
      .pkt_lat_o (pkt_lat),
      .irq_lat_o (irq_lat),
      .wake_o    (wake_o)
   );

endmodule

// File: rtl/lpw_checker.sv
module lpw_checker #(
   parameter int LONG_CYC = 1229,
   parameter int CW       = 11
) (
   input logic          clk,
   input logic          rst_n,
   input logic          live,
   input logic [CW-1:0] cnt,
   input logic          if_reset,
   input logic          if_enable,
   input logic          wake,
   input logic          linkon,
   input logic          bus_reset,
   input logic          pkt_lat,
   input logic          irq_lat
);

   assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      if_reset |=> !if_reset);

   assert_no_pulse_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      if_reset |-> if_enable);

   assert_disable_at_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(if_enable) |-> ($past(cnt) == CW'(LONG_CYC) && !$past(live)));

   assert_return_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      live |=> (if_enable && !wake));

   assert_pkt_ignored_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (live && linkon) |=> !pkt_lat);

   assert_busrst_clears_pkt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> !pkt_lat);

   assert_busrst_keeps_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!live && bus_reset && irq_lat) |=> irq_lat);

   assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pkt_lat && !irq_lat) |-> !wake);

   assert_cnt_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(LONG_CYC));

endmodule

bind lps_wake_ctrl lpw_checker #(.LONG_CYC(LONG_CYC), .CW(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .live      (live_s),
   .cnt       (drop_cnt),
   .if_reset  (if_reset_o),
   .if_enable (if_enable_o),
   .wake      (wake_o),
   .linkon    (linkon_pkt_i),
   .bus_reset (bus_reset_i),
   .pkt_lat   (pkt_lat),
   .irq_lat   (irq_lat)
);

// File: tb/sim_lps_wake_ctrl.sv
module sim_lps_wake_ctrl;

   localparam int SHORT = 59;
   localparam int LONG  = 1229;
   localparam int DIV   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic link = 1'b1, pkt = 1'b0, brst = 1'b0;
   logic pev = 1'b0, tmo = 1'b0, pfl = 1'b0, lop = 1'b0, rsm = 1'b0;
   logic if_reset, if_enable, wake;

   int n_chk = 0, n_err = 0, cycles = 0;
   int pulses = 0, rises = 0;
   logic wake_prev = 1'b0;
   string tag = "R1";

   // behavioural reference state
   logic m_s1 = 1'b1, m_s2 = 1'b1;
   int   m_len = 0, m_edges = 0;
   logic m_en = 1'b1, m_pul = 1'b0, m_pkt = 1'b0, m_irq = 1'b0;

   always #10 clk = ~clk;

   lps_wake_ctrl #(.SHORT_CYC(SHORT), .LONG_CYC(LONG), .WAKE_DIV(DIV), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .link_pwr_i(link), .linkon_pkt_i(pkt),
      .bus_reset_i(brst), .port_event_i(pev), .timeout_i(tmo), .pwr_fail_i(pfl),
      .loop_i(lop), .resume_int_i(rsm),
      .if_reset_o(if_reset), .if_enable_o(if_enable), .wake_o(wake));

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 1'b1; m_s2 = 1'b1; m_len = 0; m_en = 1'b1;
         m_pul = 1'b0; m_pkt = 1'b0; m_irq = 1'b0; m_edges = 0;
      end else begin
         logic s, want, n_en, n_pul, n_pkt, n_irq;
         int n_len;
         s     = m_s2;
         want  = pev | (rsm & (tmo | pfl | lop));
         n_len = s ? 0 : ((m_len >= LONG) ? LONG : m_len + 1);
         n_en  = s ? 1'b1 : ((m_len == LONG) ? 1'b0 : m_en);
         n_pul = s && (m_len > SHORT) && m_en;
         n_pkt = s ? 1'b0 : (brst ? 1'b0 : (m_pkt | pkt));
         n_irq = s ? 1'b0 : (m_irq | want);
         m_s2 = m_s1; m_s1 = link;
         m_len = n_len; m_en = n_en; m_pul = n_pul; m_pkt = n_pkt; m_irq = n_irq;
         m_edges++;
      end
   end

   function automatic logic exp_wake();
      return (m_pkt | m_irq) && (((m_edges / (DIV/2)) % 2) == 1);
   endfunction

   task automatic chk(input string t, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual %0d expected %0d at cycle %0d", t, what, act, exp, cycles);
      end
   endtask

   // per-cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         chk(tag, "if_reset_o", int'(if_reset), int'(m_pul));
         chk(tag, "if_enable_o", int'(if_enable), int'(m_en));
         chk(tag, "wake_o", int'(wake), int'(exp_wake()));
         if (if_reset) pulses++;
         if (wake && !wake_prev) rises++;
         wake_prev = wake;
      end
      if (cycles > 150000) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drop(input int len);
      @(negedge clk) link = 1'b0;
      idle(len);
      link = 1'b1;
      idle(6);
   endtask

   task automatic strobe_pkt();
      @(negedge clk) pkt = 1'b1;
      @(negedge clk) pkt = 1'b0;
   endtask

   task automatic strobe_brst();
      @(negedge clk) brst = 1'b1;
      @(negedge clk) brst = 1'b0;
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset enable", int'(if_enable), 1);
      chk("R1", "reset if_reset", int'(if_reset), 0);
      chk("R1", "reset wake", int'(wake), 0);

      tag = "R3"; pulses = 0; drop(30);
      chk("R3", "pulses short 30", pulses, 0);
      pulses = 0; drop(SHORT);
      chk("R3", "pulses at lower bound", pulses, 0);
      tag = "R2"; pulses = 0; drop(SHORT + 1);
      chk("R2", "pulses just above lower bound", pulses, 1);
      tag = "R3"; pulses = 0; drop(LONG);
      chk("R3", "pulses at upper bound", pulses, 1);

      tag = "R4"; pulses = 0;
      @(negedge clk) link = 1'b0;
      idle(LONG + 4);
      chk("R4", "disabled after long", int'(if_enable), 0);
      link = 1'b1; idle(6);
      chk("R4", "pulses after long", pulses, 0);
      chk("R5", "enable restored", int'(if_enable), 1);

      tag = "R6";
      strobe_pkt(); idle(20);
      chk("R6", "pkt while active no wake rises", rises, 0);

      tag = "R9";
      @(negedge clk) link = 1'b0;
      idle(100);
      strobe_pkt(); idle(7);
      rises = 0; idle(40);
      chk("R9", "wake rises in 40 cycles", rises, 5);
      tag = "R8";
      strobe_brst(); idle(3); rises = 0; idle(20);
      chk("R8", "pkt-only wake stopped by bus reset", rises, 0);
      @(negedge clk) begin pkt = 1'b1; brst = 1'b1; end
      @(negedge clk) begin pkt = 1'b0; brst = 1'b0; end
      idle(3); rises = 0; idle(20);
      chk("R8", "bus reset beats same-cycle packet", rises, 0);
      tag = "R5";
      strobe_pkt(); idle(10);
      link = 1'b1; idle(6); rises = 0; idle(20);
      chk("R5", "wake stopped by return", rises, 0);

      tag = "R7";
      @(negedge clk) rsm = 1'b1;
      @(negedge clk) link = 1'b0;
      idle(40); rises = 0; idle(24);
      chk("R7", "resume alone no wake", rises, 0);
      @(negedge clk) link = 1'b1; idle(6);
      @(negedge clk) tmo = 1'b1;
      idle(10);
      @(negedge clk) link = 1'b0;
      idle(10); rises = 0; idle(24);
      chk("R7", "armed on later inactive edge", rises, 3);
      tag = "R8";
      strobe_brst(); idle(3); rises = 0; idle(24);
      chk("R8", "irq wake survives bus reset", rises, 3);
      @(negedge clk) link = 1'b1; rsm = 1'b0; tmo = 1'b0;
      idle(6);

      tag = "R7";
      @(negedge clk) pev = 1'b1;
      @(negedge clk) pev = 1'b0;
      @(negedge clk) link = 1'b0;
      idle(10); rises = 0; idle(24);
      chk("R7", "transient port event ignored while active", rises, 0);
      @(negedge clk) pev = 1'b1;
      @(negedge clk) pev = 1'b0;
      idle(8); rises = 0; idle(24);
      chk("R7", "port event latched while inactive", rises, 3);

      tag = "R10"; pulses = 0;
      idle(3000);
      chk("R10", "still disabled after 3000", int'(if_enable), 0);
      link = 1'b1; idle(6);
      chk("R10", "no pulse after saturated dropout", pulses, 0);
      chk("R10", "enable after saturated dropout", int'(if_enable), 1);

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule